// File: doc/BRIEF.md
# Vector Element Move and Broadcast Unit

This unit handles element-level data movement for a 256-bit vector lane set that can also run as a 128-bit vector. It covers eight operations. Two insert into one indexed element: a general scalar, or element 0 of a source vector. Two extract an indexed element into a 64-bit scalar, one sign-extending and one zero-extending. Three replicate across every element: the scalar, an indexed source element, or source element 0. The last picks an indexed source element into element 0 and clears the rest. Elements are 8, 16, 32, 64 or 128 bits wide.

The operands are the scalar, a source vector and the prior destination contents. The prior destination is the base that the two insert operations modify. One registered stage follows the datapath. A valid strobe produces a one-cycle done pulse with the result. Register files, instruction decode and fetch sit outside the block.

Top module: `vmov_unit`

## Requirements
- R1: After reset `vec_o` and `scalar_o` are zero, and `done_o` and `illegal_o` are low.
- R2: Insert scalar (`op_i`=0) writes the low 8/16/32/64 bits of `scalar_i` into element `idx` of `dst_i` and keeps every other element of `dst_i`. `size_i` encodes 0=byte, 1=half, 2=word, 3=double, 4=quad (128 bits).
- R3: Extract (`op_i`=1 signed, 2 unsigned) returns source element `idx` on `scalar_o`. The signed form sign-extends it to 64 bits and the unsigned form zero-extends it.
- R4: Scalar replicate (`op_i`=3) copies the low element-width bits of `scalar_i` into every element: 16 byte lanes in 128-bit mode and 32 in 256-bit mode.
- R5: Indexed replicate (`op_i`=4, 128-bit mode only) copies source element `idx` into every destination element.
- R6: Element-0 replicate (`op_i`=5, 256-bit mode only) copies source element 0 into every destination element. This includes quad size, which gives 2 lanes.
- R7: Pick (`op_i`=6, 256-bit mode, word or double) places source element `idx` in destination element 0 and clears every higher bit.
- R8: Insert element 0 (`op_i`=7, 256-bit mode, word or double) writes source element 0 into element `idx` of `dst_i` and keeps the other elements.
- R9: When `wide_i`=0, bits 255:128 of every vector result are zero.
- R10: Only the low log2(lanes) bits of `idx_i` are used. Lanes is 128/element-width or 256/element-width, depending on the mode.
- R11: `done_o` is high exactly in the cycle after a cycle with `valid_i` high, and that is when the result appears.
- R12: A size/mode combination outside the set legal for the op sets `illegal_o` with `done_o`, and leaves `vec_o` and `scalar_o` unchanged. Legal sets: ops 0-2 allow byte to double in 128-bit mode and word/double in 256-bit mode. Op 3 allows byte to double in both modes. Op 4 allows byte to double in 128-bit mode only. Op 5 allows byte to quad in 256-bit mode only. Ops 6-7 allow word/double in 256-bit mode only.
- R13: Extract ops leave `vec_o` unchanged, and all other ops leave `scalar_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| size_i | input | 3 | Element size code |
| wide_i | input | 1 | 1 = 256-bit mode, 0 = 128-bit mode |
| idx_i | input | 5 | Element index |
| scalar_i | input | 64 | Scalar operand |
| src_i | input | 256 | Source vector |
| dst_i | input | 256 | Prior destination contents |
| vec_o | output | 256 | Destination vector result |
| scalar_o | output | 64 | Scalar result |
| done_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Unsupported combination, valid with done_o |

## Verification
The assertions check the following on every cycle:
- the done timing against the strobe;
- that the outputs hold when nothing completes, when an illegal combination completes, and when the op does not target that output;
- that the upper half is zero after a 128-bit vector op;
- zero extension of unsigned byte extracts;
- the clearing of everything above a picked word.

Element placement cannot be checked per cycle, so the directed scenarios cover it. They check which lane receives an insert, that unrelated lanes are preserved, that replication is correct for every size, that sign extension is right, and that high index bits are masked. Each result is compared against an element-level reference.

// File: rtl/vmov_pkg.sv
package vmov_pkg;
  localparam int VEC_W   = 256;
  localparam int SCL_W   = 64;
  localparam int MIN_EW  = 8;
  localparam int NSZ     = 5;
  localparam int LOG_MAX = $clog2(VEC_W / MIN_EW);
  localparam int IDX_W   = LOG_MAX;

  typedef enum logic [2:0] {
    OP_INS, OP_EXT_S, OP_EXT_U, OP_REP_SCL,
    OP_REP_IDX, OP_REP_E0, OP_PICK, OP_INS_E0
  } op_e;

  typedef enum logic [2:0] {SZ_B, SZ_H, SZ_W, SZ_D, SZ_Q} size_e;
endpackage

// File: rtl/vmov_ctl.sv
module vmov_ctl
  import vmov_pkg::*;
(
  input  op_e              op_i,
  input  size_e            size_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             legal_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vec_wr_o,
  output logic             scl_wr_o
);
  logic b_to_d, w_or_d, b_to_q;
  int   lane_log;

  assign b_to_d = (size_i <= SZ_D);
  assign w_or_d = (size_i == SZ_W) || (size_i == SZ_D);
  assign b_to_q = (size_i <= SZ_Q);

  always_comb begin
    unique case (op_i)
      OP_INS, OP_EXT_S, OP_EXT_U: legal_o = wide_i ? w_or_d : b_to_d;
      OP_REP_SCL:                 legal_o = b_to_d;
      OP_REP_IDX:                 legal_o = !wide_i && b_to_d;
      OP_REP_E0:                  legal_o = wide_i && b_to_q;
      default:                    legal_o = wide_i && w_or_d;
    endcase
  end

  assign scl_wr_o = (op_i == OP_EXT_S) || (op_i == OP_EXT_U);
  assign vec_wr_o = !scl_wr_o;

  // lanes in mode = 2**lane_log; index is masked to that range
  always_comb begin
    lane_log = (wide_i ? LOG_MAX : LOG_MAX - 1) - int'(size_i);
    if (lane_log < 0) lane_log = 0;
    idx_o = idx_i & IDX_W'((1 << lane_log) - 1);
  end
endmodule

// File: rtl/vmov_path.sv
module vmov_path
  import vmov_pkg::*;
(
  input  op_e              op_i,
  input  size_e            size_i,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SCL_W-1:0] scalar_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_i,
  output logic [VEC_W-1:0] vec_o,
  output logic [SCL_W-1:0] scl_o
);
  logic [VEC_W-1:0] rep_scl [NSZ];
  logic [VEC_W-1:0] rep_idx [NSZ];
  logic [VEC_W-1:0] rep_e0  [NSZ];
  logic [VEC_W-1:0] ins_scl [NSZ];
  logic [VEC_W-1:0] ins_e0  [NSZ];
  logic [VEC_W-1:0] pick    [NSZ];
  logic [SCL_W-1:0] ext_s   [NSZ];
  logic [SCL_W-1:0] ext_u   [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int EB = MIN_EW << g;
    localparam int N  = VEC_W / EB;
    int               sh;
    logic [EB-1:0]    e_idx, e_src0, e_scl;
    logic [VEC_W-1:0] slot;

    assign sh     = int'(idx_i) * EB;
    assign e_idx  = EB'(src_i >> sh);
    assign e_src0 = src_i[EB-1:0];
    assign e_scl  = EB'(scalar_i);
    assign slot   = VEC_W'({EB{1'b1}}) << sh;

    assign rep_scl[g] = {N{e_scl}};
    assign rep_idx[g] = {N{e_idx}};
    assign rep_e0[g]  = {N{e_src0}};
    assign ins_scl[g] = (dst_i & ~slot) | (VEC_W'(e_scl) << sh);
    assign ins_e0[g]  = (dst_i & ~slot) | (VEC_W'(e_src0) << sh);
    assign pick[g]    = VEC_W'(e_idx);

    if (EB < SCL_W) begin : g_narrow
      assign ext_s[g] = {{(SCL_W-EB){e_idx[EB-1]}}, e_idx};
      assign ext_u[g] = SCL_W'(e_idx);
    end else if (EB == SCL_W) begin : g_full
      assign ext_s[g] = SCL_W'(e_idx);
      assign ext_u[g] = SCL_W'(e_idx);
    end else begin : g_none
      assign ext_s[g] = '0;
      assign ext_u[g] = '0;
    end
  end

  int               si;
  logic [VEC_W-1:0] raw;

  always_comb begin
    si = (int'(size_i) < NSZ) ? int'(size_i) : 0;
    unique case (op_i)
      OP_INS:     raw = ins_scl[si];
      OP_REP_SCL: raw = rep_scl[si];
      OP_REP_IDX: raw = rep_idx[si];
      OP_REP_E0:  raw = rep_e0[si];
      OP_PICK:    raw = pick[si];
      OP_INS_E0:  raw = ins_e0[si];
      default:    raw = '0;
    endcase
    vec_o = wide_i ? raw : (raw & VEC_W'({(VEC_W/2){1'b1}}));
    scl_o = (op_i == OP_EXT_S) ? ext_s[si] : ext_u[si];
  end
endmodule

// File: rtl/vmov_unit.sv
module vmov_unit
  import vmov_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [2:0]         op_i,
  input  logic [2:0]         size_i,
  input  logic               wide_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [SCL_W-1:0]   scalar_i,
  input  logic [VEC_W-1:0]   src_i,
  input  logic [VEC_W-1:0]   dst_i,
  output logic [VEC_W-1:0]   vec_o,
  output logic [SCL_W-1:0]   scalar_o,
  output logic               done_o,
  output logic               illegal_o
);
  op_e              op;
  size_e            size;
  logic             legal, vec_wr, scl_wr;
  logic [IDX_W-1:0] idx_eff;
  logic [VEC_W-1:0] vec_res;
  logic [SCL_W-1:0] scl_res;

  assign op   = op_e'(op_i);
  assign size = size_e'(size_i);

  vmov_ctl i_ctl (
    .op_i     (op),
    .size_i   (size),
    .wide_i   (wide_i),
    .idx_i    (idx_i),
    .legal_o  (legal),
    .idx_o    (idx_eff),
    .vec_wr_o (vec_wr),
    .scl_wr_o (scl_wr)
  );

  vmov_path i_path (
    .op_i     (op),
    .size_i   (size),
    .wide_i   (wide_i),
    .idx_i    (idx_eff),
    .scalar_i (scalar_i),
    .src_i    (src_i),
    .dst_i    (dst_i),
    .vec_o    (vec_res),
    .scl_o    (scl_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o     <= '0;
      scalar_o  <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= valid_i;
      illegal_o <= valid_i && !legal;
      if (valid_i && legal && vec_wr) vec_o    <= vec_res;
      if (valid_i && legal && scl_wr) scalar_o <= scl_res;
    end
  end
endmodule

// File: rtl/vmov_unit_chk.sv
module vmov_unit_chk
  import vmov_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic [2:0]       size_i,
  input logic             wide_i,
  input logic [VEC_W-1:0] vec_o,
  input logic [SCL_W-1:0] scalar_o,
  input logic             done_o,
  input logic             illegal_o
);
  assert_done_after_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  assert_no_spurious_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  assert_illegal_holds_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && illegal_o) |-> ($stable(vec_o) && $stable(scalar_o)));

  assert_idle_holds_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(vec_o) && $stable(scalar_o)));

  assert_scalar_untouched_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(op_i) != 3'(OP_EXT_S) && $past(op_i) != 3'(OP_EXT_U))
      |-> $stable(scalar_o));

  assert_upper_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && !$past(wide_i) &&
     $past(op_i) != 3'(OP_EXT_S) && $past(op_i) != 3'(OP_EXT_U))
      |-> (vec_o[VEC_W-1:VEC_W/2] == '0));

  assert_zext_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && $past(op_i) == 3'(OP_EXT_U) && $past(size_i) == 3'(SZ_B))
      |-> (scalar_o[SCL_W-1:8] == '0));

  assert_pick_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && $past(op_i) == 3'(OP_PICK) && $past(size_i) == 3'(SZ_W))
      |-> (vec_o[VEC_W-1:32] == '0));
endmodule

bind vmov_unit vmov_unit_chk i_vmov_unit_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .size_i    (size_i),
  .wide_i    (wide_i),
  .vec_o     (vec_o),
  .scalar_o  (scalar_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/test_vmov_unit.sv
module test_vmov_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic [2:0]   size_i = '0;
  logic         wide_i = 1'b0;
  logic [4:0]   idx_i = '0;
  logic [63:0]  scalar_i = '0;
  logic [255:0] src_i = '0;
  logic [255:0] dst_i = '0;
  logic [255:0] vec_o;
  logic [63:0]  scalar_o;
  logic         done_o, illegal_o;

  int checks = 0;
  int failures = 0;
  logic [255:0] exp_vec = '0;
  logic [63:0]  exp_scl = '0;
  logic         exp_ill = 1'b0;

  always #4 clk_i = ~clk_i;

  vmov_unit i_vmov_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .size_i(size_i), .wide_i(wide_i), .idx_i(idx_i), .scalar_i(scalar_i),
    .src_i(src_i), .dst_i(dst_i), .vec_o(vec_o), .scalar_o(scalar_o),
    .done_o(done_o), .illegal_o(illegal_o)
  );

  task automatic check(string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] pat(int seed);
    logic [255:0] v;
    for (int b = 0; b < 32; b++) v[8*b +: 8] = 8'(b * 29 + seed);
    return v;
  endfunction

  function automatic logic [127:0] get_el(logic [255:0] v, int eb, int k);
    logic [127:0] r = '0;
    for (int b = 0; b < eb; b++) r[b] = v[k*eb + b];
    return r;
  endfunction

  function automatic logic [255:0] set_el(logic [255:0] v, int eb, int k, logic [127:0] e);
    logic [255:0] r = v;
    for (int b = 0; b < eb; b++) r[k*eb + b] = e[b];
    return r;
  endfunction

  // legal sets from R12
  function automatic bit legal_ref(int op, int sz, bit wide);
    case (op)
      0, 1, 2: return wide ? (sz == 2 || sz == 3) : (sz <= 3);
      3:       return sz <= 3;
      4:       return !wide && sz <= 3;
      5:       return wide && sz <= 4;
      default: return wide && (sz == 2 || sz == 3);
    endcase
  endfunction

  task automatic model(int op, int sz, bit wide, int idx, logic [63:0] sc,
                       logic [255:0] src, logic [255:0] dst);
    int eb, n, k;
    logic [255:0] v;
    logic [127:0] e;
    exp_ill = !legal_ref(op, sz, wide);
    if (exp_ill) return;
    eb = 8 << sz;
    n  = (wide ? 256 : 128) / eb;
    k  = idx % n;
    v  = '0;
    case (op)
      0: v = set_el(dst, eb, k, 128'(sc));
      1, 2: begin
        e = get_el(src, eb, k);
        exp_scl = 64'(e);
        if (op == 1) for (int b = eb; b < 64; b++) exp_scl[b] = e[eb-1];
      end
      3: for (int i = 0; i < n; i++) v = set_el(v, eb, i, 128'(sc));
      4: begin e = get_el(src, eb, k); for (int i = 0; i < n; i++) v = set_el(v, eb, i, e); end
      5: begin e = get_el(src, eb, 0); for (int i = 0; i < n; i++) v = set_el(v, eb, i, e); end
      6: v = set_el('0, eb, 0, get_el(src, eb, k));
      default: v = set_el(dst, eb, k, get_el(src, eb, 0));
    endcase
    if (op != 1 && op != 2) begin
      if (!wide) v[255:128] = '0;
      exp_vec = v;
    end
  endtask

  task automatic run(string req, int op, int sz, bit wide, int idx, logic [63:0] sc,
                     logic [255:0] src, logic [255:0] dst);
    model(op, sz, wide, idx, sc, src, dst);
    @(negedge clk_i);
    op_i = 3'(op); size_i = 3'(sz); wide_i = wide; idx_i = 5'(idx);
    scalar_i = sc; src_i = src; dst_i = dst; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R11", "done", 256'(done_o), 256'(1));
    check("R12", "illegal", 256'(illegal_o), 256'(exp_ill));
    check(req, "vec", vec_o, exp_vec);
    check(req, "scalar", 256'(scalar_o), 256'(exp_scl));
    @(negedge clk_i);
    check("R11", "done low", 256'(done_o), 256'(0));
  endtask

  task automatic t_reset;
    check("R1", "vec", vec_o, '0);
    check("R1", "scalar", 256'(scalar_o), '0);
    check("R1", "done", 256'(done_o), '0);
    check("R1", "illegal", 256'(illegal_o), '0);
  endtask

  task automatic t_insert;
    for (int sz = 0; sz < 4; sz++) run("R2", 0, sz, 0, 1 + sz, 64'hfedc_ba98_7654_3210, pat(3), pat(90));
    run("R2", 0, 2, 1, 7, 64'h0123_4567_89ab_cdef, pat(5), pat(77));
    run("R2", 0, 3, 1, 2, 64'h0123_4567_89ab_cdef, pat(5), pat(77));
  endtask

  task automatic t_extract;
    for (int sz = 0; sz < 4; sz++) begin
      run("R3", 1, sz, 0, 3, '0, pat(200), '0);
      run("R3", 2, sz, 0, 3, '0, pat(200), '0);
    end
    run("R3", 1, 2, 1, 6, '0, pat(131), '0);
    run("R3", 2, 3, 1, 3, '0, pat(131), '0);
  endtask

  task automatic t_rep_scalar;
    for (int sz = 0; sz < 4; sz++) begin
      run("R4", 3, sz, 0, 0, 64'h8899_aabb_ccdd_eeff, '0, '0);
      run("R4", 3, sz, 1, 0, 64'h1122_3344_5566_7788, '0, '0);
    end
  endtask

  task automatic t_rep_idx;
    for (int sz = 0; sz < 4; sz++) run("R5", 4, sz, 0, 1, '0, pat(17), '0);
  endtask

  task automatic t_rep_e0;
    for (int sz = 0; sz < 5; sz++) run("R6", 5, sz, 1, 0, '0, pat(61 + sz), '0);
  endtask

  task automatic t_pick;
    run("R7", 6, 2, 1, 5, '0, pat(44), pat(9));
    run("R7", 6, 3, 1, 3, '0, pat(44), pat(9));
  endtask

  task automatic t_ins_e0;
    run("R8", 7, 2, 1, 6, '0, pat(150), pat(33));
    run("R8", 7, 3, 1, 1, '0, pat(150), pat(33));
  endtask

  task automatic t_upper;
    run("R9", 5, 0, 1, 0, '0, pat(255), '0);
    run("R9", 0, 1, 0, 2, 64'h5a5a, '0, pat(100));
  endtask

  task automatic t_idx_wrap;
    run("R10", 0, 0, 0, 5'h13, 64'h00c3, '0, pat(8));
    run("R10", 1, 3, 0, 5'h1f, '0, pat(222), '0);
    run("R10", 6, 2, 1, 5'h1c, '0, pat(71), '0);
  endtask

  task automatic t_illegal;
    run("R9", 3, 3, 1, 0, 64'hdead_beef_0bad_f00d, '0, '0);
    run("R3", 1, 0, 0, 0, '0, pat(250), '0);
    run("R12", 0, 0, 1, 0, 64'hff, '0, pat(1));
    run("R12", 4, 2, 1, 0, '0, pat(2), '0);
    run("R12", 6, 2, 0, 0, '0, pat(3), '0);
    run("R12", 2, 0, 1, 0, '0, pat(4), '0);
    run("R12", 3, 4, 0, 0, 64'h1, '0, '0);
    run("R12", 5, 5, 1, 0, '0, pat(6), '0);
    run("R12", 7, 1, 1, 0, '0, pat(7), pat(8));
  endtask

  task automatic t_outputs_kept;
    run("R13", 2, 1, 0, 4, '0, pat(140), '0);
    run("R13", 3, 2, 1, 0, 64'h7777_0000_1234_5678, '0, '0);
    run("R13", 1, 0, 0, 9, '0, pat(180), '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_insert();
    t_extract();
    t_rep_scalar();
    t_rep_idx();
    t_rep_e0();
    t_pick();
    t_ins_e0();
    t_upper();
    t_idx_wrap();
    t_illegal();
    t_outputs_kept();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule